// File: doc/BRIEF.md
# SPDIF Copy-Permit Bit Patcher

The block sits inline on a biphase-mark SPDIF stream. It takes one half-bit per enabled clock and returns the same stream one enabled clock later. A separate frame aligner provides three strobes that mark the end of the Z, X and Y preambles.

Counting from the Z preamble that opens a 192-frame block, the block locates the channel-status bit of the two subframes of frame 2. That bit carries status byte 0, bit 2, which is the copy-permit flag. If the incoming flag is 0, the block rewrites it so the subframe reads as 1. It then inverts the parity bit that follows. Every step works on raw line half-bits: the block never decodes the stream to NRZ and never holds a half-bit back.

When the preamble strobes stop arriving at the slots the block expects, it gives up on the current block and passes data through until the next Z.

Top module: `spdif_copy_patcher`

## Requirements
- R1: On each clock with `en` high, `dataOut` takes the value of `dataIn` from that clock, inverted only in the cases R5 and R7 name. The new value is visible after that clock edge.
- R2: On each clock with `en` low, `dataOut` holds its value, whatever `dataIn` and the strobes carry.
- R3: Subframe timing is counted from the preamble strobes.
  - A strobe is asserted together with the 8th, and last, preamble half-bit of a subframe, which is half-bit index 7.
  - Half-bit 0 of a subframe is its first preamble half-bit.
  - The Z strobe opens subframe 0 of frame 0. Subframes then alternate Y, X, Y, X.
  - Only subframes 4 and 5 (frame 2) are ever altered. Frames 0 and 1 pass unchanged even when their copy flag is 0.
- R4: The first half of the copy bit (half-bit 60) is always passed unchanged.
- R5: If the second half of the copy bit (half-bit 61) equals the first half, the copy bit encodes 0. The block then inverts that half, so the emitted pair differs and reads as 1.
- R6: If the copy bit already encodes 1, the whole subframe passes unchanged, parity included.
- R7: After a copy rewrite, the first half of the parity bit (half-bit 62) is inverted. Its second half (half-bit 63) and all later half-bits pass unchanged.
- R8: If user-bit half-bit 59 equals copy half-bit 60, the pair is invalid biphase. That subframe passes unchanged.
- R9: The same procedure is applied to the Y subframe (subframe 5) after the X subframe (subframe 4), with each handled on its own terms.
- R10: If the expected X or Y strobe is missing at half-bit 7 of subframes 1 to 5, the block stops patching. The rest of that block passes unchanged.
- R11: After subframe 5 the block waits for a new Z strobe. Later frames pass unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| en | input | 1 | Half-bit enable: one line half-bit per high cycle |
| dataIn | input | 1 | Incoming biphase-mark half-bit |
| zStrobe | input | 1 | Z preamble seen; high with preamble half-bit 7 |
| xStrobe | input | 1 | X preamble seen; high with preamble half-bit 7 |
| yStrobe | input | 1 | Y preamble seen; high with preamble half-bit 7 |
| dataOut | output | 1 | Patched biphase-mark half-bit, one enabled clock late |

## Verification
A wrong half-bit position or subframe count inside the block shows up as a single inverted half-bit at the wrong place in the output. It can also show up as a missing inversion at half-bits 61 and 62 of frame 2. Either way, the error appears exactly one enabled clock after the affected input half-bit.

A lost or stale parity-pending flag shows up as a biphase violation at half-bit 62. A tracking state that fails to drop after an absent strobe shows up as an inversion in a subframe that should pass unchanged.

Since every output half-bit is compared with a model-encoded stream, a fault is caught in the cycle it appears.

// File: rtl/spdif_copy_pkg.sv
package spdif_copy_pkg;
  // Strobes from control to datapath, valid only together with en.
  typedef struct packed {
    logic copyFirst;   // copy bit, first half present on dataIn
    logic copySecond;  // copy bit, second half present on dataIn
    logic parityFirst; // parity bit, first half present on dataIn
  } patch_ctl_t;
endpackage

// File: rtl/spdif_copy_ctrl.sv
module spdif_copy_ctrl
  import spdif_copy_pkg::*;
#(
  parameter int SUB_HALVES = 64,
  parameter int PRE_HALVES = 8,
  parameter int COPY_BIT   = 30,
  parameter int PATCH_FRAME = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       en,
  input  logic       zStrobe,
  input  logic       xStrobe,
  input  logic       yStrobe,
  output patch_ctl_t ctl
);
  localparam int POS_W    = $clog2(SUB_HALVES);
  localparam int PATCH_SF = 2 * PATCH_FRAME;
  localparam int LAST_SF  = PATCH_SF + 1;
  localparam int SF_W     = $clog2(LAST_SF + 1);
  localparam logic [POS_W-1:0] PRE_END  = POS_W'(PRE_HALVES - 1);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(SUB_HALVES - 1);
  localparam logic [POS_W-1:0] COPY_A   = POS_W'(2 * COPY_BIT);
  localparam logic [POS_W-1:0] COPY_B   = POS_W'(2 * COPY_BIT + 1);
  localparam logic [POS_W-1:0] PAR_A    = POS_W'(2 * COPY_BIT + 2);

  typedef enum logic {ST_IDLE, ST_TRACK} track_t;

  track_t           state;
  logic [POS_W-1:0] pos;     // index of the last accepted half-bit
  logic [SF_W-1:0]  sfIdx;   // subframe count since Z
  logic [POS_W-1:0] curPos;  // index of the half-bit on dataIn now
  logic [SF_W-1:0]  nextSf;
  logic             slotOk;
  logic             inPatch;

  always_comb begin
    curPos  = (pos == LAST_POS) ? '0 : pos + POS_W'(1);
    nextSf  = sfIdx + SF_W'(1);
    slotOk  = nextSf[0] ? yStrobe : xStrobe;
    inPatch = (state == ST_TRACK) &&
              (sfIdx == SF_W'(PATCH_SF) || sfIdx == SF_W'(LAST_SF));
    ctl.copyFirst   = en && inPatch && !zStrobe && curPos == COPY_A;
    ctl.copySecond  = en && inPatch && !zStrobe && curPos == COPY_B;
    ctl.parityFirst = en && inPatch && !zStrobe && curPos == PAR_A;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      pos   <= '0;
      sfIdx <= '0;
    end else if (en) begin
      if (zStrobe) begin
        state <= ST_TRACK;
        pos   <= PRE_END;
        sfIdx <= '0;
      end else if (state == ST_TRACK) begin
        pos <= curPos;
        if (curPos == PRE_END) begin
          if (slotOk) sfIdx <= nextSf;
          else        state <= ST_IDLE;
        end
        if (curPos == LAST_POS && sfIdx == SF_W'(LAST_SF)) state <= ST_IDLE;
      end
    end
  end

  // R3: at most one patch strobe per cycle
  p_one_strobe_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.copyFirst, ctl.copySecond, ctl.parityFirst}));
endmodule

// File: rtl/spdif_copy_dpath.sv
module spdif_copy_dpath
  import spdif_copy_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       en,
  input  logic       dataIn,
  input  patch_ctl_t ctl,
  output logic       dataOut
);
  logic prevIn;        // last accepted input half-bit
  logic pairOk;        // user second half differs from copy first half
  logic parityPending; // copy was rewritten, parity first half next
  logic copyFix;
  logic flip;

  always_comb begin
    copyFix = ctl.copySecond && pairOk && (dataIn == prevIn);
    flip    = copyFix || (ctl.parityFirst && parityPending);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataOut       <= 1'b0;
      prevIn        <= 1'b0;
      pairOk        <= 1'b0;
      parityPending <= 1'b0;
    end else if (en) begin
      dataOut       <= dataIn ^ flip;
      prevIn        <= dataIn;
      parityPending <= copyFix;
      if (ctl.copyFirst) pairOk <= (dataIn != prevIn);
    end
  end

  // R1: plain pass-through outside patch slots
  p_pass_r1: assert property (@(posedge clk) disable iff (!rstN)
    (en && !ctl.copySecond && !ctl.parityFirst) |=> dataOut == $past(dataIn));
  // R2: output frozen while disabled
  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !en |=> $stable(dataOut));
  // R4: first copy half never altered
  p_copy_first_r4: assert property (@(posedge clk) disable iff (!rstN)
    (en && ctl.copyFirst) |=> dataOut == $past(dataIn));
  // R5: with a valid pair, emitted copy halves always differ
  p_copy_one_r5: assert property (@(posedge clk) disable iff (!rstN)
    (en && ctl.copySecond && pairOk) |=> dataOut != $past(dataOut));
  // R7: pending parity repair inverts the parity first half
  p_parity_fix_r7: assert property (@(posedge clk) disable iff (!rstN)
    (en && ctl.parityFirst && parityPending) |=> dataOut != $past(dataIn));
endmodule

// File: rtl/spdif_copy_patcher.sv
module spdif_copy_patcher
  import spdif_copy_pkg::*;
#(
  parameter int SUB_HALVES  = 64,
  parameter int PRE_HALVES  = 8,
  parameter int COPY_BIT    = 30,
  parameter int PATCH_FRAME = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic en,
  input  logic dataIn,
  input  logic zStrobe,
  input  logic xStrobe,
  input  logic yStrobe,
  output logic dataOut
);
  patch_ctl_t ctl;

  spdif_copy_ctrl #(
    .SUB_HALVES(SUB_HALVES), .PRE_HALVES(PRE_HALVES),
    .COPY_BIT(COPY_BIT), .PATCH_FRAME(PATCH_FRAME)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .en(en),
    .zStrobe(zStrobe), .xStrobe(xStrobe), .yStrobe(yStrobe),
    .ctl(ctl)
  );

  spdif_copy_dpath dpath_i (
    .clk(clk), .rstN(rstN), .en(en), .dataIn(dataIn),
    .ctl(ctl), .dataOut(dataOut)
  );
endmodule

// File: tb/spdif_copy_patcher_tb_top.sv
module spdif_copy_patcher_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic en = 1'b0;
  logic dataIn = 1'b0;
  logic zStrobe = 1'b0, xStrobe = 1'b0, yStrobe = 1'b0;
  logic dataOut;

  int nChecks = 0;
  int nFails = 0;

  localparam int MAXH = 1024;
  logic inBits  [MAXH];
  logic expBits [MAXH];
  logic [1:0] strb [MAXH]; // 1=Z 2=X 3=Y
  int   nHalves;

  always #10 clk = ~clk;

  spdif_copy_patcher dut_i (
    .clk(clk), .rstN(rstN), .en(en), .dataIn(dataIn),
    .zStrobe(zStrobe), .xStrobe(xStrobe), .yStrobe(yStrobe),
    .dataOut(dataOut)
  );

  task automatic check(input logic act, input logic exp, input string tag, input int idx);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s half-bit %0d: got %b expected %b", tag, idx, act, exp);
    end
  endtask

  task automatic encSub(input int base, input logic [31:0] nrz, input logic [7:0] pre,
                        inout logic lvl, input bit toExp);
    logic h1, h2;
    for (int i = 0; i < 8; i++) begin
      h1 = lvl ? ~pre[7-i] : pre[7-i];
      if (toExp) expBits[base+i] = h1; else inBits[base+i] = h1;
    end
    lvl = lvl ? ~pre[0] : pre[0];
    for (int b = 4; b < 32; b++) begin
      h1 = ~lvl;
      h2 = nrz[b] ? ~h1 : h1;
      if (toExp) begin expBits[base+2*b] = h1; expBits[base+2*b+1] = h2; end
      else begin inBits[base+2*b] = h1; inBits[base+2*b+1] = h2; end
      lvl = h2;
    end
  endtask

  // Build nSub subframes. copyV: copy flag per subframe. badSf: subframe
  // with an invalid user/copy pair. dropSf: subframe whose strobe is missing.
  task automatic build(input int nSub, input logic [7:0] copyV, input int badSf, input int dropSf);
    logic lvlIn, lvlExp;
    logic [31:0] nrz, pat;
    logic [7:0] pre;
    bit live;
    lvlIn = 1'b0; lvlExp = 1'b0;
    live = 1'b1;
    for (int s = 0; s < nSub; s++) begin
      int base;
      base = s * 64;
      nrz = $urandom;
      nrz[28] = 1'b0;
      nrz[30] = copyV[s];
      nrz[31] = ^nrz[30:4];
      pre = (s == 0) ? 8'b11101000 : (s[0] ? 8'b11100100 : 8'b11100010);
      if (s == dropSf) live = 1'b0;
      pat = nrz;
      if (live && (s == 4 || s == 5) && s != badSf && !copyV[s]) begin
        pat[30] = 1'b1;
        pat[31] = ~nrz[31];
      end
      encSub(base, nrz, pre, lvlIn, 1'b0);
      encSub(base, pat, pre, lvlExp, 1'b1);
      if (s == badSf) begin
        inBits[base+59]  = inBits[base+60];
        expBits[base+59] = inBits[base+60];
      end
      for (int i = 0; i < 64; i++) strb[base+i] = 2'd0;
      if (s != dropSf) strb[base+7] = (s == 0) ? 2'd1 : (s[0] ? 2'd3 : 2'd2);
    end
    nHalves = nSub * 64;
  endtask

  task automatic doReset();
    en = 1'b0; zStrobe = 0; xStrobe = 0; yStrobe = 0; dataIn = 0;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic runStream(input string tag, input bit gaps);
    for (int k = 0; k < nHalves; k++) begin
      @(negedge clk);
      if (k > 0) check(dataOut, expBits[k-1], tag, k-1);
      if (gaps && (k % 5 == 3)) begin
        en = 1'b0; dataIn = ~dataIn;
        zStrobe = 1'b1; xStrobe = 1'b1; yStrobe = 1'b1;
        @(negedge clk);
        check(dataOut, expBits[k-1], "R2 hold", k-1);
      end
      en = 1'b1;
      dataIn = inBits[k];
      zStrobe = (strb[k] == 2'd1);
      xStrobe = (strb[k] == 2'd2);
      yStrobe = (strb[k] == 2'd3);
    end
    @(negedge clk);
    check(dataOut, expBits[nHalves-1], tag, nHalves-1);
    en = 1'b0; zStrobe = 0; xStrobe = 0; yStrobe = 0;
  endtask

  task automatic testReset();
    doReset();
    @(negedge clk);
    check(dataOut, 1'b0, "R1 reset", -1);
  endtask

  // R3 R5 R7 R9 R11: copy 0 everywhere, frames 0,1,3 untouched
  task automatic testPatchBoth();
    doReset(); build(8, 8'h00, -1, -1); runStream("R3/R5/R7/R9/R11", 1'b0);
  endtask

  // R6: copy already 1 everywhere
  task automatic testAlreadySet();
    doReset(); build(6, 8'hFF, -1, -1); runStream("R6", 1'b0);
  endtask

  // R4 R9: X needs patch, Y already 1
  task automatic testMixed();
    doReset(); build(6, 8'b0010_0000, -1, -1); runStream("R4/R9", 1'b0);
  endtask

  // R8: invalid pair in X, Y still patched
  task automatic testBadPair();
    doReset(); build(6, 8'h00, 4, -1); runStream("R8", 1'b0);
  endtask

  // R10: missing strobes
  task automatic testDropY();
    doReset(); build(6, 8'h00, -1, 3); runStream("R10 sf3", 1'b0);
    doReset(); build(6, 8'h00, -1, 5); runStream("R10 sf5", 1'b0);
  endtask

  // R1 R2: gapped enable with patching
  task automatic testGaps();
    doReset(); build(6, 8'h00, -1, -1); runStream("R1/R2 gaps", 1'b1);
  endtask

  initial begin
    void'($urandom(7));
    testReset();
    testPatchBoth();
    testAlreadySet();
    testMixed();
    testBadPair();
    testDropY();
    testGaps();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #(20 * 100000);
    nChecks++; nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule